// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Window

This block compares a divided reference signal against a divided oscillator feedback signal and produces a coarse charge-pump correction. A two-state up/down detector records which rising edge came first. The correction is presented as a drive value plus an output enable, so a pad or an analog pump outside the block can make it three-state.

Each comparison ends when both edges have arrived. The number of system clock cycles between the two edges is measured and compared with a programmable window. After a set number of consecutive comparisons fall inside the window, the block reports lock on an active-low indicator. It then releases the coarse output to high impedance, which leaves fine correction to other circuitry. A single comparison outside the window withdraws lock and gives control back to the coarse output.

Top module: `pfd_lock_window`

## Requirements
- R1: After reset `pump_oe` is 0 and `lock_n` is 1.
- R2: A rising edge on `ref_in` with no pending feedback edge makes `pump_oe`=1 and `pump_up`=1 from the next clock, while unlocked, until the comparison completes.
- R3: A rising edge on `fb_in` with no pending reference edge makes `pump_oe`=1 and `pump_up`=0 from the next clock, while unlocked, until the comparison completes.
- R4: A comparison completes on the clock where the second edge is sampled. Both detector states clear on that clock, so `pump_oe` is 0 after it. Edges sampled on the same clock complete at once with error 0 and no pump activity.
- R5: Only rising edges count. An input held high starts one comparison at most.
- R6: The measured error is the number of clocks between the two sampled edges. It is inside the window when it is less than or equal to `win_cyc`.
- R7: `lock_n` goes to 0 on the clock that completes the 4th consecutive in-window comparison.
- R8: A completed comparison outside the window sets `lock_n` to 1 on that clock and restarts the consecutive count.
- R9: While `lock_n` is 0, `pump_oe` is 0 whatever the detector state.
- R10: With `win_cyc`=0, only comparisons whose edges arrive on the same clock count as inside the window.
- R11: A repeated leading edge before the trailing edge arrives keeps the same pump direction. The comparison still ends at the first trailing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided reference signal |
| fb_in | input | 1 | Divided oscillator feedback signal |
| win_cyc | input | WIN_W (6) | Lock window in clock cycles |
| pump_up | output | 1 | Coarse drive value: 1 pumps up, 0 pumps down |
| pump_oe | output | 1 | Coarse output enable; 0 means high impedance |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
A stuck or wrongly set up/down state shows on the next clock as a wrong `pump_up` or a `pump_oe` that does not drop after the trailing edge. A miscounted error or a wrong window comparison changes the lock outcome, at the latest on the fourth in-window comparison or the first out-of-window one. A broken consecutive-count register shows as `lock_n` falling one comparison early or late. It also shows as lock surviving a bad comparison, which the bench sees on the clock that completes that comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef struct packed {
      logic up;
      logic dn;
   } pump_req_t;

   localparam int unsigned PFD_DEF_WIN_W = 6;
   localparam int unsigned PFD_DEF_LOCK  = 4;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
   parameter int unsigned N      = 2,
   parameter bit          RISING = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] evt
);
   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   generate
      if (RISING) begin : g_rise
         assign evt = lvl & ~prev;
      end else begin : g_fall
         assign evt = ~lvl & prev;
      end
   endgenerate
endmodule

// File: rtl/pfd_core.sv
module pfd_core
   import pfd_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_evt,
   input  logic             fb_evt,
   output pump_req_t        req,
   output logic             done,
   output logic [CNT_W-1:0] err
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             up_nx, dn_nx, pending;
   logic [CNT_W-1:0] cnt;

   assign up_nx   = req.up | ref_evt;
   assign dn_nx   = req.dn | fb_evt;
   assign done    = up_nx & dn_nx;
   assign pending = req.up | req.dn;
   assign err     = !pending ? '0 : ((cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= '0;
         cnt <= '0;
      end else begin
         if (done) begin
            req <= '0;
            cnt <= '0;
         end else begin
            req.up <= up_nx;
            req.dn <= dn_nx;
            if (pending && cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end
      end
   end

   AST_UPDN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(req.up && req.dn)); // R4
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> (cnt == '0)); // R6
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned WIN_W      = 6,
   parameter int unsigned LOCK_COUNT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [CNT_W-1:0] err,
   input  logic [WIN_W-1:0] win,
   output logic             in_win,
   output logic             locked
);
   localparam int unsigned SW       = $clog2(LOCK_COUNT + 1);
   localparam logic [SW-1:0] LOCK_TGT = SW'(LOCK_COUNT);

   logic [SW-1:0] streak;

   assign in_win = err <= {{(CNT_W-WIN_W){1'b0}}, win};
   assign locked = (streak == LOCK_TGT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) streak <= '0;
      else if (done) begin
         if (!in_win)     streak <= '0;
         else if (!locked) streak <= streak + 1'b1;
      end
   end

   AST_STREAK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      streak <= LOCK_TGT); // R7
endmodule

// File: rtl/pfd_lock_window.sv
module pfd_lock_window
   import pfd_pkg::*;
#(
   parameter int unsigned WIN_W      = PFD_DEF_WIN_W,
   parameter int unsigned LOCK_COUNT = PFD_DEF_LOCK,
   parameter bit          RISING     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             fb_in,
   input  logic [WIN_W-1:0] win_cyc,
   output logic             pump_up,
   output logic             pump_oe,
   output logic             lock_n
);
   localparam int unsigned CNT_W = WIN_W + 2;

   generate
      if (WIN_W < 1 || WIN_W > 16) begin : g_bad_win
         $error("WIN_W out of range");
      end
      if (LOCK_COUNT < 1 || LOCK_COUNT > 255) begin : g_bad_lock
         $error("LOCK_COUNT out of range");
      end
   endgenerate

   logic [1:0]       evt;
   pump_req_t        req;
   logic             done, in_win, locked;
   logic [CNT_W-1:0] err;

   pfd_edge_det #(.N(2), .RISING(RISING)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({fb_in, ref_in}), .evt(evt)
   );

   pfd_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ref_evt(evt[0]), .fb_evt(evt[1]),
      .req(req), .done(done), .err(err)
   );

   pfd_lock_qual #(.CNT_W(CNT_W), .WIN_W(WIN_W), .LOCK_COUNT(LOCK_COUNT)) u_lock (
      .clk(clk), .rst_n(rst_n), .done(done), .err(err), .win(win_cyc),
      .in_win(in_win), .locked(locked)
   );

   assign pump_up = req.up;
   assign pump_oe = (req.up | req.dn) & ~locked;
   assign lock_n  = ~locked;

   AST_QUIET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_n |-> !pump_oe); // R9
   AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_n) |-> $past(done && in_win)); // R7
   AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_n) |-> $past(done && !in_win)); // R8
   AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      pump_oe |-> (req.up || req.dn)); // R2
endmodule

// File: tb/pfd_lock_window_tb.sv
module pfd_lock_window_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       fb_in = 1'b0;
   logic [5:0] win_cyc = 6'd2;
   logic       pump_up, pump_oe, lock_n;
   int         total = 0;
   int         bad = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   pfd_lock_window u_dut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .win_cyc(win_cyc), .pump_up(pump_up), .pump_oe(pump_oe), .lock_n(lock_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one comparison: d clocks between edges, lead selects ref (1) or fb (0)
   task automatic compare(input int d, input bit ref_lead, input bit exp_oe, input string req);
      @(negedge clk);
      if (d == 0) begin
         ref_in = 1'b1; fb_in = 1'b1;
         @(negedge clk);
         ref_in = 1'b0; fb_in = 1'b0;
         chk(pump_oe == 1'b0, "R4", pump_oe, 0);
      end else begin
         if (ref_lead) ref_in = 1'b1; else fb_in = 1'b1;
         @(negedge clk);
         if (ref_lead) ref_in = 1'b0; else fb_in = 1'b0;
         chk(pump_oe == exp_oe, req, pump_oe, exp_oe);
         if (exp_oe) chk(pump_up == ref_lead, req, pump_up, ref_lead);
         repeat (d - 1) @(negedge clk);
         if (ref_lead) fb_in = 1'b1; else ref_in = 1'b1;
         @(negedge clk);
         fb_in = 1'b0; ref_in = 1'b0;
         chk(pump_oe == 1'b0, "R4", pump_oe, 0);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(pump_oe == 1'b0, "R1", pump_oe, 0);
      chk(lock_n == 1'b1, "R1", lock_n, 1);
   endtask

   task automatic t_lead;
      win_cyc = 6'd2;
      compare(4, 1'b1, 1'b1, "R2");
      compare(4, 1'b0, 1'b1, "R3");
      chk(lock_n == 1'b1, "R8", lock_n, 1);
   endtask

   task automatic t_simul;
      compare(0, 1'b1, 1'b0, "R4");
      chk(lock_n == 1'b1, "R4", lock_n, 1);
   endtask

   task automatic t_level;
      @(negedge clk); ref_in = 1'b1;
      repeat (8) @(negedge clk);
      fb_in = 1'b1;
      @(negedge clk); fb_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(pump_oe == 1'b0, "R5", pump_oe, 0);
      ref_in = 1'b0;
      repeat (2) @(negedge clk);
      chk(pump_oe == 1'b0, "R5", pump_oe, 0);
   endtask

   task automatic t_freq;
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
      repeat (2) @(negedge clk); ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
      chk(pump_oe == 1'b1 && pump_up == 1'b1, "R11", {pump_oe, pump_up}, 3);
      fb_in = 1'b1;
      @(negedge clk); fb_in = 1'b0;
      chk(pump_oe == 1'b0, "R11", pump_oe, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_lock;
      win_cyc = 6'd5;
      for (int i = 0; i < 4; i++) begin
         compare(5, i[0], 1'b1, "R6");
         chk(lock_n == (i < 3), "R7", lock_n, (i < 3));
      end
      compare(3, 1'b1, 1'b0, "R9");
      chk(lock_n == 1'b0, "R9", lock_n, 0);
      compare(6, 1'b0, 1'b0, "R9");
      chk(lock_n == 1'b1, "R8", lock_n, 1);
      compare(2, 1'b1, 1'b1, "R8");
      chk(lock_n == 1'b1, "R8", lock_n, 1);
   endtask

   task automatic t_win0;
      win_cyc = 6'd0;
      compare(1, 1'b1, 1'b1, "R10");
      for (int i = 0; i < 4; i++) begin
         compare(0, 1'b1, 1'b0, "R10");
         chk(lock_n == (i < 3), "R10", lock_n, (i < 3));
      end
      compare(1, 1'b0, 1'b0, "R10");
      chk(lock_n == 1'b1, "R10", lock_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_lead();
      t_simul();
      t_level();
      t_freq();
      t_lock();
      t_win0();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule